// File: doc/BRIEF.md
# Four-Entry Store Posting Buffer

This block sits between a processor core's store port and main memory. It lets the core post a store (address, 32-bit data and byte enables) in one cycle and carry on while the buffer writes the store to memory in the background. Up to four stores can be pending. A store of any size takes a whole entry, so four byte stores fill the buffer as surely as four word stores do.

The drain side sends entries to memory strictly in the order they were posted. Each write takes a number of cycles that depends on page locality. A write to a 1 KB page other than the one last written costs four cycles, and so does the first write after reset. A write to the same page as the previous write costs one cycle. If the core presents a store while all four entries are occupied and none retires in that cycle, the core is stalled. The stall then holds until every pending entry has reached memory. An empty flag lets ordering logic wait for the buffer to drain.

Top module: `store_wbuf`

## Requirements
- R1: While reset is held and in the first cycle after it, `buf_empty` is 1, `st_stall` is 0 and `mem_we` is 0.
- R2: A store presented while fewer than four entries are occupied is accepted in that cycle, and `st_stall` stays 0.
- R3: Each accepted store takes exactly one entry whatever its byte enables. After four stores are accepted with no retirement, a fifth store presented in a cycle with no retirement sees `st_stall` = 1.
- R4: Entries are written to memory in posting order. `mem_addr`, `mem_data` and `mem_be` equal the posted values unchanged while `mem_we` is 1.
- R5: The page of an address is bits [31:10]. A write costs 4 cycles when it is the first write since reset or its page differs from the page of the previous write, and 1 cycle otherwise. A store posted in cycle t into an empty buffer is written in cycle t+1+cost. A store already waiting behind another entry is written `cost` cycles after that entry's write.
- R6: Once a store has been refused because the buffer was full, `st_stall` stays 1 until the buffer is empty, even across retirements. A store still presented is accepted in the first cycle the buffer is empty.
- R7: A store presented while all four entries are occupied, in a cycle where an entry retires (`mem_we` = 1), is accepted without a stall.
- R8: `buf_empty` is 1 exactly when no store is pending.
- R9: `mem_we` is never 1 while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core presents a store |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_stall | output | 1 | Core must hold the store and wait |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 32 | Write address, valid with `mem_we` |
| mem_data | output | 32 | Write data, valid with `mem_we` |
| mem_be | output | 4 | Write byte enables, valid with `mem_we` |
| buf_empty | output | 1 | No store pending |

## Verification
Single isolated stores are posted in a sequence of pages. The sequence includes a first write after reset, writes that stay in one page, writes that cross a 1 KB boundary, and writes that change only the upper address bits. Measuring each write's delay therefore separates the near cost from the far cost and shows whether the page compare covers the whole upper field. A back-to-back burst of byte stores followed by a fifth store separates a refused store that forces a complete flush from a partial-drain release. The same burst with the fifth store delayed by exactly one cycle, to the cycle where the first entry retires, checks that a slot freed in the same cycle is reused.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int PAGE_LSB = 10;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wb_entry_t;

    function automatic logic same_page(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:PAGE_LSB] == b[ADDR_W-1:PAGE_LSB];
    endfunction
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_ent,
    input  logic      pop,
    output wb_entry_t head,
    output wb_entry_t second,
    output logic [CW-1:0] count
);
    wb_entry_t slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PW'(g)) slot[g] <= push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head   = slot[rd_ptr];
    assign second = slot[bump(rd_ptr)];
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
    import wbuf_pkg::*;
#(
    parameter int CW        = 3,
    parameter int FAR_COST  = 4,
    parameter int NEAR_COST = 1,
    localparam int TW = $clog2(FAR_COST + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [CW-1:0] count,
    input  wb_entry_t head,
    input  wb_entry_t second,
    output logic      retire
);
    logic              busy;
    logic [TW-1:0]     timer;
    logic              last_valid;
    logic [ADDR_W-1:0] last_addr;

    logic              ref_valid;
    logic [ADDR_W-1:0] ref_addr;
    wb_entry_t         cand;
    logic              cand_avail;
    logic [TW-1:0]     cand_load;

    assign retire = busy && (timer == '0);

    // The entry after the one retiring now is priced against the retiring page.
    always_comb begin
        ref_valid  = retire ? 1'b1 : last_valid;
        ref_addr   = retire ? head.addr : last_addr;
        cand       = retire ? second : head;
        cand_avail = retire ? (count > CW'(1)) : (count != '0);
        if (ref_valid && same_page(cand.addr, ref_addr))
            cand_load = TW'(NEAR_COST - 1);
        else
            cand_load = TW'(FAR_COST - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            timer      <= '0;
            last_valid <= 1'b0;
            last_addr  <= '0;
        end else begin
            if (!busy || retire) begin
                busy  <= cand_avail;
                timer <= cand_load;
            end else begin
                timer <= timer - TW'(1);
            end
            if (retire) begin
                last_valid <= 1'b1;
                last_addr  <= head.addr;
            end
        end
    end
endmodule

// File: rtl/wbuf_admit.sv
module wbuf_admit #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic st_valid,
    input  logic [CW-1:0] count,
    input  logic retire,
    output logic accept,
    output logic stall
);
    logic flushing;
    logic full;

    assign full   = (count == CW'(DEPTH));
    assign accept = st_valid && !flushing && (!full || retire);
    assign stall  = flushing || (st_valid && full && !retire);

    always_ff @(posedge clk) begin
        if (rst)
            flushing <= 1'b0;
        else if (flushing)
            flushing <= !(retire && count == CW'(1));
        else
            flushing <= st_valid && full && !retire;
    end
endmodule

// File: rtl/store_wbuf.sv
module store_wbuf
    import wbuf_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int FAR_COST  = 4,
    parameter int NEAR_COST = 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_stall,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic              buf_empty
);
    wb_entry_t     in_ent, head, second;
    logic [CW-1:0] fifo_count;
    logic          accept, retire;

    assign in_ent = '{addr: st_addr, data: st_data, be: st_be};

    wbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(accept), .push_ent(in_ent), .pop(retire),
        .head(head), .second(second), .count(fifo_count)
    );

    wbuf_drain #(.CW(CW), .FAR_COST(FAR_COST), .NEAR_COST(NEAR_COST)) u_drain (
        .clk(clk), .rst(rst), .count(fifo_count), .head(head), .second(second),
        .retire(retire)
    );

    wbuf_admit #(.DEPTH(DEPTH)) u_admit (
        .clk(clk), .rst(rst), .st_valid(st_valid), .count(fifo_count),
        .retire(retire), .accept(accept), .stall(st_stall)
    );

    assign mem_we    = retire;
    assign mem_addr  = head.addr;
    assign mem_data  = head.data;
    assign mem_be    = head.be;
    assign buf_empty = (fifo_count == '0);
endmodule

// File: rtl/store_wbuf_chk.sv
module store_wbuf_chk
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_stall,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              buf_empty,
    input logic [CW-1:0]     fifo_count
);
    // R3: occupancy never exceeds the entry count
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_count) <= DEPTH);

    // R9: no memory write from an empty buffer
    assert_no_empty_write_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !buf_empty);

    // R5: back-to-back writes are only possible within one page
    assert_back_to_back_same_page_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> same_page(mem_addr, $past(mem_addr)));

    // R2: an unstalled store takes exactly one entry
    assert_one_entry_per_store_R2: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_stall) |=>
            int'(fifo_count) == int'($past(fifo_count)) + 1 - int'($past(mem_we)));

    // R8: an empty buffer with no new store stays empty and silent
    assert_idle_stays_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (buf_empty && !st_valid) |=> (buf_empty && !mem_we));
endmodule

bind store_wbuf store_wbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_stall(st_stall),
    .mem_we(mem_we), .mem_addr(mem_addr), .buf_empty(buf_empty),
    .fifo_count(fifo_count)
);

// File: tb/store_wbuf_tb.sv
module store_wbuf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // {addr, data, be, expected cost}
    localparam logic [71:0] VEC [NV] = '{
        {32'h0000_0400, 32'hA5A5_0001, 4'b1111, 4'd4},
        {32'h0000_0404, 32'hA5A5_0002, 4'b0001, 4'd1},
        {32'h0000_07FC, 32'hA5A5_0003, 4'b1000, 4'd1},
        {32'h0000_0800, 32'hA5A5_0004, 4'b0011, 4'd4},
        {32'h8000_0800, 32'hA5A5_0005, 4'b1100, 4'd4},
        {32'h8000_0BF0, 32'hA5A5_0006, 4'b0100, 4'd1},
        {32'h8000_0400, 32'hA5A5_0007, 4'b0110, 4'd4}
    };

    logic clk = 0, rst = 1;
    logic st_valid = 0;
    logic [31:0] st_addr = 0, st_data = 0;
    logic [3:0] st_be = 0;
    logic st_stall, mem_we, buf_empty;
    logic [31:0] mem_addr, mem_data;
    logic [3:0] mem_be;

    int cyc = 0, checks = 0, fails = 0, wr_n = 0;
    bit done = 0;
    logic [31:0] wr_addr [64];
    logic [31:0] wr_data [64];
    logic [3:0]  wr_be   [64];
    int          wr_cyc  [64];
    bit stall_log [32];
    int acc_cyc [5];

    store_wbuf u_dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .buf_empty(buf_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (!rst && mem_we && wr_n < 64) begin
        wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_data;
        wr_be[wr_n] = mem_be; wr_cyc[wr_n] = cyc; wr_n++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Byte-store burst of 4 plus a fifth store; gap holds the fifth back one cycle.
    task automatic run_burst(input logic [31:0] base, input bit gap, output int c0);
        int idx = 0;
        c0 = cyc;
        for (int i = 0; i < 32; i++) begin
            if (idx < 5 && !(gap && i == 4)) begin
                st_valid = 1; st_addr = base + 32'(4 * idx);
                st_data = base ^ 32'(idx + 1); st_be = 4'(1 << (idx % 4));
            end else st_valid = 0;
            @(negedge clk);
            stall_log[i] = st_stall;
            if (st_valid && !st_stall) begin acc_cyc[idx] = i; idx++; end
            step();
        end
        st_valid = 0;
    endtask

    initial begin
        int c0, w0, wait_n;
        step(); step();
        @(negedge clk);
        chk(buf_empty && !st_stall && !mem_we, "R1", "reset outputs",
            {buf_empty, st_stall, mem_we}, 3'b100);
        step(); rst = 0;
        @(negedge clk);
        chk(buf_empty && !st_stall && !mem_we, "R1", "after reset",
            {buf_empty, st_stall, mem_we}, 3'b100);
        step();

        for (int v = 0; v < NV; v++) begin
            int pc, n0;
            n0 = wr_n;
            st_valid = 1; st_addr = VEC[v][71:40]; st_data = VEC[v][39:8];
            st_be = VEC[v][7:4]; pc = cyc;
            @(negedge clk);
            chk(!st_stall, "R2", "no stall on free entry", st_stall, 0);
            step(); st_valid = 0;
            @(negedge clk);
            chk(!buf_empty, "R8", "pending after post", buf_empty, 0);
            wait_n = 0;
            while (wr_n == n0 && wait_n < 20) begin step(); @(negedge clk); wait_n++; end
            chk(wr_n == n0 + 1 && wr_cyc[n0] - pc == int'(VEC[v][3:0]) + 1, "R5",
                "write latency", wr_cyc[n0] - pc, int'(VEC[v][3:0]) + 1);
            chk(wr_addr[n0] == VEC[v][71:40] && wr_data[n0] == VEC[v][39:8] &&
                wr_be[n0] == VEC[v][7:4], "R4", "write contents",
                {wr_addr[n0], wr_data[n0], wr_be[n0]}, VEC[v][71:4]);
            step(); step();
            @(negedge clk);
            chk(buf_empty && wr_n == n0 + 1, "R9", "empty and silent after drain",
                {buf_empty, 8'(wr_n - n0)}, 9'h101);
            step();
        end

        // Full buffer refused store: complete flush before acceptance
        w0 = wr_n;
        run_burst(32'h0001_0000, 0, c0);
        chk(acc_cyc[3] == 3 && stall_log[4], "R3", "four byte stores fill buffer",
            {acc_cyc[3], stall_log[4]}, {32'd3, 1'b1});
        chk(stall_log[5] && stall_log[6] && stall_log[7] && stall_log[8], "R6",
            "stall held through flush",
            {stall_log[5], stall_log[6], stall_log[7], stall_log[8]}, 4'hF);
        chk(!stall_log[9] && acc_cyc[4] == 9, "R6", "accepted when empty",
            acc_cyc[4], 9);
        chk(wr_n == w0 + 5 && wr_cyc[w0] - c0 == 5 && wr_cyc[w0+1] - c0 == 6 &&
            wr_cyc[w0+3] - c0 == 8 && wr_cyc[w0+4] - c0 == 11, "R5",
            "burst write cycles", {wr_cyc[w0] - c0, wr_cyc[w0+4] - c0}, {32'd5, 32'd11});
        for (int k = 0; k < 5; k++)
            chk(wr_addr[w0+k] == 32'h0001_0000 + 32'(4*k) &&
                wr_be[w0+k] == 4'(1 << (k % 4)) &&
                wr_data[w0+k] == (32'h0001_0000 ^ 32'(k + 1)), "R4", "burst order",
                wr_addr[w0+k], 32'h0001_0000 + 32'(4*k));

        // Full buffer with same-cycle retirement: store accepted
        w0 = wr_n;
        run_burst(32'h0002_0000, 1, c0);
        chk(!stall_log[5] && acc_cyc[4] == 5, "R7", "accept on retire cycle",
            {stall_log[5], acc_cyc[4]}, 5);
        chk(wr_n == w0 + 5 && wr_cyc[w0] - c0 == 5 && wr_cyc[w0+4] - c0 == 9, "R7",
            "fifth write timing", wr_cyc[w0+4] - c0, 9);
        @(negedge clk);
        chk(buf_empty && !mem_we, "R8", "empty at end", buf_empty, 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule